// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds 4-bit operands one bit per clock through a single full-adder slice. The only state besides the two data registers is a one-bit carry. It is therefore a two-state Mealy machine: the sum bit depends on the present carry as well as on the two incoming bits. Operand bits arrive on a serial input, least significant bit first. Each group of four clocks shifts one complete operand into the operand register. During the same four clocks, the operand received in the previous group is added into the total register.

Because loading and adding overlap, two shift registers are enough; a separate result register is not needed. The total register always holds the running sum of every operand completed before the current group, modulo 16. A start pulse clears both registers and the carry, and restarts the group count. A one-cycle done flag marks the end of each group. At that point the total register can be read in parallel. The carry storage can be built from a D or a JK flip-flop, and both give the same results.

Top module: `serial_accum_adder`

## Requirements
- R1: A synchronous reset or a start pulse clears the operand register, the total register, the carry and the group count. The cycle after it shows both registers at 0 and done at 0.
- R2: On every other clock, the operand register shifts right by one bit and the serial input enters at bit 3. After four clocks, the first bit received sits at bit 0.
- R3: On every other clock, the total register shifts right. Bit 3 takes the XOR of operand bit 0, total bit 0 and the stored carry.
- R4: Within a group, the stored carry takes the majority of operand bit 0, total bit 0 and the stored carry.
- R5: After the fourth clock of each group, the carry is forced to 0. Any carry out of bit 3 is dropped, so totals wrap modulo 16 and nothing leaks into the next group.
- R6: After group k+1 following a start, the total register equals the sum of the operands fed in groups 1 to k, modulo 16.
- R7: Feeding 1011, then 0010, then 0000 gives operand 0010 and total 1011 after clock 8, and total 1101 after clock 12.
- R8: Done is 1 for exactly the one cycle after the fourth clock of each group, and 0 at all other times.
- R9: The JK-flip-flop carry variant (J = a AND b, K = NOR of a and b) produces the same register and done values as the D variant on every cycle.
- R10: A start pulse in the middle of a group discards the partial group, and counting restarts from the first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Synchronous clear and restart of the group count |
| serIn | input | 1 | Serial operand bit, least significant first |
| regA | output | 4 | Operand register, read in parallel |
| regB | output | 4 | Running total register, read in parallel |
| done | output | 1 | One-cycle pulse after each completed group |

## Verification
The assertions check four things on every cycle:
- the shift of the operand register;
- the Mealy sum bit entering the total register;
- the forced carry clear at group ends;
- the single-cycle shape and placement of done, and the clearing effect of start.

Only the bench scenarios can show the arithmetic over whole operands: totals modulo 16 across many operand pairs, accumulation over several groups, the worked 1011 plus 0010 sequence, and a restart in mid-group. The bench also shows that the JK and D carry variants agree cycle by cycle.

// File: rtl/serial_accum_pkg.sv
package serial_accum_pkg;
  typedef enum logic {CARRY_D = 1'b0, CARRY_JK = 1'b1} carryStyle_e;

  typedef struct packed {
    logic clear;     // wipe registers, carry, counter
    logic shift;     // advance one bit position
    logic groupEnd;  // this clock handles the last bit of a group
  } addStrobe_t;
endpackage

// File: rtl/serial_accum_ctrl.sv
module serial_accum_ctrl
  import serial_accum_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output addStrobe_t strb,
  output logic       done
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             clearNow;

  assign clearNow      = rst | start;
  assign strb.clear    = clearNow;
  assign strb.shift    = ~clearNow;
  assign strb.groupEnd = ~clearNow & (bitCnt == LAST);

  always_ff @(posedge clk) begin
    if (clearNow) begin
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
      done   <= strb.groupEnd;
    end
  end
endmodule

// File: rtl/serial_accum_datapath.sv
module serial_accum_datapath
  import serial_accum_pkg::*;
#(
  parameter int          WIDTH       = 4,
  parameter carryStyle_e CARRY_STYLE = CARRY_D
) (
  input  logic             clk,
  input  addStrobe_t       strb,
  input  logic             serIn,
  output logic [WIDTH-1:0] regA,
  output logic [WIDTH-1:0] regB,
  output logic             carryQ
);
  logic aBit, bBit, sumBit, carryNext;

  assign aBit   = regA[0];
  assign bBit   = regB[0];
  assign sumBit = aBit ^ bBit ^ carryQ;

  // Carry state element, variant picked by parameter
  generate
    if (CARRY_STYLE == CARRY_JK) begin : g_jk
      logic jIn, kIn;
      assign jIn       = aBit & bBit;
      assign kIn       = ~(aBit | bBit);
      assign carryNext = (jIn & ~carryQ) | (~kIn & carryQ);
    end else begin : g_d
      assign carryNext = (aBit & bBit) | (aBit & carryQ) | (bBit & carryQ);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      regA   <= '0;
      regB   <= '0;
      carryQ <= 1'b0;
    end else if (strb.shift) begin
      regA   <= {serIn, regA[WIDTH-1:1]};
      regB   <= {sumBit, regB[WIDTH-1:1]};
      carryQ <= strb.groupEnd ? 1'b0 : carryNext;
    end
  end
endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder
  import serial_accum_pkg::*;
#(
  parameter int          WIDTH       = 4,
  parameter carryStyle_e CARRY_STYLE = CARRY_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             serIn,
  output logic [WIDTH-1:0] regA,
  output logic [WIDTH-1:0] regB,
  output logic             done
);
  addStrobe_t strb;
  logic       carryQ;

  serial_accum_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .strb(strb), .done(done)
  );

  serial_accum_datapath #(.WIDTH(WIDTH), .CARRY_STYLE(CARRY_STYLE)) u_dp (
    .clk(clk), .strb(strb), .serIn(serIn),
    .regA(regA), .regB(regB), .carryQ(carryQ)
  );
endmodule

// File: rtl/serial_accum_adder_chk.sv
module serial_accum_adder_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             serIn,
  input logic [WIDTH-1:0] regA,
  input logic [WIDTH-1:0] regB,
  input logic             done,
  input logic             carryQ,
  input logic             groupEnd
);
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    start |=> (regA == '0 && regB == '0 && !done && !carryQ));

  assert_a_shift_R2: assert property (@(posedge clk) disable iff (rst)
    !start |=> regA == {$past(serIn), $past(regA[WIDTH-1:1])});

  assert_sum_bit_R3: assert property (@(posedge clk) disable iff (rst)
    !start |=> regB[WIDTH-1] == ($past(regA[0]) ^ $past(regB[0]) ^ $past(carryQ)));

  assert_carry_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (groupEnd && !start) |=> !carryQ);

  assert_done_after_group_R8: assert property (@(posedge clk) disable iff (rst)
    (groupEnd && !start) |=> done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind serial_accum_adder serial_accum_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .serIn(serIn),
  .regA(regA), .regB(regB), .done(done),
  .carryQ(carryQ), .groupEnd(strb.groupEnd)
);

// File: tb/serial_accum_adder_bench.sv
module serial_accum_adder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic serIn = 1'b0;
  logic [3:0] dA, dB, jA, jB;
  logic dDone, jDone;
  int checks = 0;
  int fails = 0;
  int jkMism = 0;

  always #5 clk = ~clk;

  serial_accum_adder u_serial_accum_adder (
    .clk(clk), .rst(rst), .start(start), .serIn(serIn),
    .regA(dA), .regB(dB), .done(dDone)
  );

  serial_accum_adder #(.CARRY_STYLE(serial_accum_pkg::CARRY_JK)) u_jk (
    .clk(clk), .rst(rst), .start(start), .serIn(serIn),
    .regA(jA), .regB(jB), .done(jDone)
  );

  // Operand pairs {first, second}
  localparam logic [7:0] VECS [10] = '{
    8'hB2, 8'h00, 8'hFF, 8'hF1, 8'h87, 8'h5A, 8'h33, 8'h9E, 8'h78, 8'h4C
  };

  always @(negedge clk) begin
    if (!rst && (dA !== jA || dB !== jB || dDone !== jDone)) jkMism++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    serIn = b;
    @(posedge clk); #1;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    tick(1'b0);
    start = 1'b0;
  endtask

  task automatic feed(input logic [3:0] op);
    for (int i = 0; i < 4; i++) tick(op[i]);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick(1'b1);
    chk("R1 reset A", dA, 0);
    chk("R1 reset B", dB, 0);
    chk("R1 reset done", dDone, 0);
    rst = 1'b0;

    // Table walk: sum of each pair, wrap modulo 16
    for (int v = 0; v < 10; v++) begin
      logic [3:0] a, b;
      a = VECS[v][7:4];
      b = VECS[v][3:0];
      pulseStart();
      feed(a);
      chk("R2 operand loaded", dA, a);
      feed(b);
      chk("R2 second operand", dA, b);
      chk("R6 first total", dB, a);
      feed(4'h0);
      chk("R6 R5 pair total", dB, (a + b) & 4'hF);
    end

    // Worked example with timing
    pulseStart();
    for (int i = 0; i < 3; i++) tick(4'b1011 >> i);
    chk("R8 done low mid group", dDone, 0);
    tick(1'b1);
    chk("R8 done after fourth bit", dDone, 1);
    tick(1'b0);
    chk("R8 done one cycle", dDone, 0);
    tick(1'b1); tick(1'b0); tick(1'b0);
    chk("R7 A after clock 8", dA, 4'b0010);
    chk("R7 B after clock 8", dB, 4'b1011);
    feed(4'h0);
    chk("R7 B after clock 12", dB, 4'b1101);
    chk("R3 R4 sum through carries", dB, 4'hD);

    // Carry out discarded, no leak into next group
    pulseStart();
    feed(4'hF); feed(4'h1); feed(4'h0);
    chk("R5 wrap total", dB, 4'h0);
    feed(4'h0);
    chk("R5 no carry leak", dB, 4'h0);

    // Accumulation over three operands
    pulseStart();
    feed(4'h3); feed(4'h5); feed(4'h6); feed(4'h0);
    chk("R6 three operand total", dB, 4'hE);

    // Start in mid group
    pulseStart();
    tick(1'b1); tick(1'b1);
    pulseStart();
    chk("R1 start clears A", dA, 0);
    feed(4'h6); feed(4'h7);
    chk("R10 restart grouping", dB, 4'h6);
    feed(4'h0);
    chk("R10 restart total", dB, 4'hD);

    chk("R9 JK variant matches", jkMism, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule